// File: doc/BRIEF.md
# Wide Instruction Stream Decoder

This block sits at the front of an instruction pipeline for a register-machine instruction set. It takes 64-bit instruction words one at a time over a valid/ready handshake and cuts each word into its fields. It then presents one decoded record per instruction on a held output that also uses valid/ready. The record carries the raw opcode and its sub-fields, the two register numbers, the offset sign-extended to 64 bits, a 64-bit immediate and a flag that marks a double-slot instruction.

Most instructions fill one slot. One opcode starts a double-slot instruction. That instruction needs a 64-bit constant, so the decoder takes the following word as a pseudo-slot that supplies the upper 32 bits of the constant and then emits a single merged record. Malformed input produces a one-cycle error strobe and no record. Malformed input is a register number beyond the legal range, or a pseudo-slot whose non-immediate fields are not all zero.

The controller has three named states. FIRST waits for a first slot. SECOND has stored the first half of a double-slot instruction and waits for the pseudo-slot. HOLD presents a record and waits for the consumer. The transitions are as follows. FIRST goes to HOLD on an accepted valid single-slot word (take_basic). FIRST goes to SECOND on an accepted wide-start word with a legal destination (take_low). SECOND goes to HOLD on a clean pseudo-slot (take_merge). SECOND goes to FIRST on a dirty pseudo-slot (reject_pair). HOLD goes to FIRST when the consumer accepts the record (release). A word rejected in FIRST leaves the state at FIRST (reject_word).

Top module: `wide_insn_decoder`

## Requirements
- R1: When reset is released, out_valid and out_err are 0 and in_ready is 1.
- R2: The bits of a word split as follows: immediate is bits 63:32, offset is bits 31:16, source register is bits 15:12, destination register is bits 11:8 and opcode is bits 7:0. out_alu_op is opcode bits 7:4, out_src_sel is opcode bit 3 (0 selects the immediate, 1 selects the source register) and out_class is opcode bits 2:0.
- R3: out_offset is the 16-bit offset sign-extended to 64 bits. For a single-slot instruction, out_imm is the 32-bit immediate sign-extended to 64 bits.
- R4: A single-slot word whose source or destination register number exceeds 10 produces out_err high for exactly one cycle and no record.
- R5: Opcode 0x18 starts a double-slot instruction and produces no output until the next accepted word. The next word is the pseudo-slot. The record then has out_wide=1 and out_imm = {pseudo-slot immediate, first-slot immediate}. Opcode, registers and offset come from the first slot, and the first slot's source field is not range-checked.
- R6: A pseudo-slot with a nonzero opcode, register or offset field produces out_err high for exactly one cycle. The pair is dropped, and the next word is decoded as a first slot.
- R7: A wide-start word with a destination register above 10 produces out_err at once, and the next word is decoded as a first slot.
- R8: While a record is held and out_ready is 0, in_ready is 0. Any word presented in that time is ignored, and the record stays unchanged.
- R9: A record leaves when out_valid and out_ready are both high at a clock edge. out_valid then drops and in_ready returns to 1 in the next cycle.
- R10: A record or an error appears in the cycle after the clock edge that accepts the last word it depends on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 64 | Instruction slot |
| out_ready | input | 1 | Consumer accepts the record |
| out_valid | output | 1 | Decoded record valid |
| out_opcode | output | 8 | Raw opcode |
| out_class | output | 3 | Instruction class (opcode bits 2:0) |
| out_alu_op | output | 4 | Operation code (opcode bits 7:4) |
| out_src_sel | output | 1 | Operand source select (opcode bit 3) |
| out_src | output | 4 | Source register number |
| out_dst | output | 4 | Destination register number |
| out_offset | output | 64 | Sign-extended offset |
| out_imm | output | 64 | Immediate, 64-bit for double-slot |
| out_wide | output | 1 | Record came from a double-slot instruction |
| out_err | output | 1 | One-cycle malformed-input strobe |

## Verification
The hardest case to reach is a broken pair. The decoder must sit in SECOND holding a first half when a dirty pseudo-slot arrives, and afterwards it must fall back to first-slot decoding instead of staying out of step. The stimulus sends a legal wide-start word, then a pseudo-slot with only its offset set, and then an ordinary word that must decode as single-slot. A second hard case is backpressure with a competing word on the input. The bench holds out_ready low while in_valid is high with a different word, and it checks that the held record does not move.

// File: rtl/wid_pkg.sv
package wid_pkg;
    localparam int WORD_W = 64;
    localparam int XLEN   = 64;
    localparam int IMM_W  = 32;
    localparam int OFF_W  = 16;
    localparam int REG_W  = 4;
    localparam int OPC_W  = 8;
    localparam int ALU_W  = 4;
    localparam int CLS_W  = 3;

    // field order here is the bit order of a slot (MSB first)
    typedef struct packed {
        logic [IMM_W-1:0] imm;
        logic [OFF_W-1:0] off;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [OPC_W-1:0] opc;
    } slot_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
        logic [XLEN-1:0]  off;
        logic [XLEN-1:0]  imm;
        logic             wide;
    } rec_t;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_HOLD   = 2'd2
    } dec_state_t;
endpackage

// File: rtl/wid_slot_split.sv
module wid_slot_split
    import wid_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output slot_t             slot
);
    assign slot = slot_t'(word);
endmodule

// File: rtl/wid_opc_fields.sv
module wid_opc_fields
    import wid_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic [ALU_W-1:0] alu_op,
    output logic             src_sel,
    output logic [CLS_W-1:0] cls
);
    assign alu_op  = opc[OPC_W-1 -: ALU_W];
    assign src_sel = opc[CLS_W];
    assign cls     = opc[CLS_W-1:0];
endmodule

// File: rtl/wid_slot_check.sv
module wid_slot_check
    import wid_pkg::*;
#(
    parameter int unsigned    REG_MAX  = 10,
    parameter logic [7:0]     WIDE_OPC = 8'h18
) (
    input  slot_t slot,
    output logic  src_ok,
    output logic  dst_ok,
    output logic  wide_start,
    output logic  pseudo_clean
);
    localparam logic [REG_W-1:0] REG_LIM = REG_W'(REG_MAX);

    assign src_ok       = (slot.src <= REG_LIM);
    assign dst_ok       = (slot.dst <= REG_LIM);
    assign wide_start   = (slot.opc == WIDE_OPC);
    assign pseudo_clean = (slot.opc == '0) && (slot.src == '0)
                       && (slot.dst == '0) && (slot.off == '0);
endmodule

// File: rtl/wid_ctrl_fsm.sv
module wid_ctrl_fsm
    import wid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    input  logic wide_start,
    input  logic src_ok,
    input  logic dst_ok,
    input  logic pseudo_clean,
    output logic in_ready,
    output logic out_valid,
    output logic err,
    output logic take_basic,
    output logic take_low,
    output logic take_merge
);
    dec_state_t state_q, state_d;
    logic       err_set;
    logic       err_q;
    logic       accept;

    assign in_ready  = (state_q != ST_HOLD);
    assign out_valid = (state_q == ST_HOLD);
    assign accept    = in_valid && in_ready;
    assign err       = err_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIRST;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_set;
        end
    end

    // next state and strobes
    always_comb begin
        state_d    = state_q;
        err_set    = 1'b0;
        take_basic = 1'b0;
        take_low   = 1'b0;
        take_merge = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                if (accept) begin
                    if (wide_start) begin
                        if (dst_ok) begin
                            take_low = 1'b1;
                            state_d  = ST_SECOND;
                        end else begin
                            err_set  = 1'b1;
                        end
                    end else if (src_ok && dst_ok) begin
                        take_basic = 1'b1;
                        state_d    = ST_HOLD;
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            ST_SECOND: begin
                if (accept) begin
                    if (pseudo_clean) begin
                        take_merge = 1'b1;
                        state_d    = ST_HOLD;
                    end else begin
                        err_set = 1'b1;
                        state_d = ST_FIRST;
                    end
                end
            end
            ST_HOLD: begin
                if (out_ready) state_d = ST_FIRST;
            end
            default: state_d = ST_FIRST;
        endcase
    end
endmodule

// File: rtl/wide_insn_decoder.sv
module wide_insn_decoder
    import wid_pkg::*;
#(
    parameter int unsigned REG_MAX  = 10,
    parameter logic [7:0]  WIDE_OPC = 8'h18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_word,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_opcode,
    output logic [2:0]  out_class,
    output logic [3:0]  out_alu_op,
    output logic        out_src_sel,
    output logic [3:0]  out_src,
    output logic [3:0]  out_dst,
    output logic [63:0] out_offset,
    output logic [63:0] out_imm,
    output logic        out_wide,
    output logic        out_err
);
    slot_t slot;
    slot_t lo_q;
    rec_t  rec_q;
    logic  src_ok, dst_ok, wide_start, pseudo_clean;
    logic  take_basic, take_low, take_merge;

    wid_slot_split i_split (
        .word (in_word),
        .slot (slot)
    );

    wid_slot_check #(
        .REG_MAX  (REG_MAX),
        .WIDE_OPC (WIDE_OPC)
    ) i_check (
        .slot         (slot),
        .src_ok       (src_ok),
        .dst_ok       (dst_ok),
        .wide_start   (wide_start),
        .pseudo_clean (pseudo_clean)
    );

    wid_ctrl_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .wide_start   (wide_start),
        .src_ok       (src_ok),
        .dst_ok       (dst_ok),
        .pseudo_clean (pseudo_clean),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .err          (out_err),
        .take_basic   (take_basic),
        .take_low     (take_low),
        .take_merge   (take_merge)
    );

    // first half of a double-slot instruction
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (take_low) begin
            lo_q <= slot;
        end
    end

    // decoded record
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (take_basic) begin
            rec_q.opc  <= slot.opc;
            rec_q.src  <= slot.src;
            rec_q.dst  <= slot.dst;
            rec_q.off  <= {{(XLEN-OFF_W){slot.off[OFF_W-1]}}, slot.off};
            rec_q.imm  <= {{(XLEN-IMM_W){slot.imm[IMM_W-1]}}, slot.imm};
            rec_q.wide <= 1'b0;
        end else if (take_merge) begin
            rec_q.opc  <= lo_q.opc;
            rec_q.src  <= lo_q.src;
            rec_q.dst  <= lo_q.dst;
            rec_q.off  <= {{(XLEN-OFF_W){lo_q.off[OFF_W-1]}}, lo_q.off};
            rec_q.imm  <= {slot.imm, lo_q.imm};
            rec_q.wide <= 1'b1;
        end
    end

    wid_opc_fields i_opc (
        .opc     (rec_q.opc),
        .alu_op  (out_alu_op),
        .src_sel (out_src_sel),
        .cls     (out_class)
    );

    assign out_opcode = rec_q.opc;
    assign out_src    = rec_q.src;
    assign out_dst    = rec_q.dst;
    assign out_offset = rec_q.off;
    assign out_imm    = rec_q.imm;
    assign out_wide   = rec_q.wide;
endmodule

// File: rtl/wid_decoder_checker.sv
module wid_decoder_checker #(
    parameter int unsigned REG_MAX  = 10,
    parameter logic [7:0]  WIDE_OPC = 8'h18
) (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        out_ready,
    input logic        out_valid,
    input logic [7:0]  out_opcode,
    input logic [3:0]  out_src,
    input logic [3:0]  out_dst,
    input logic [63:0] out_imm,
    input logic        out_wide,
    input logic        out_err
);
    localparam logic [3:0] REG_LIM = 4'(REG_MAX);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && in_ready));

    a_r8_stall_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r8_record_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) && $stable(out_dst)));

    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    a_r4_dst_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_dst <= REG_LIM));

    a_r4_src_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wide) |-> (out_src <= REG_LIM));

    a_r6_err_no_record: assert property (@(posedge clk) disable iff (rst)
        out_err |-> !out_valid);

    a_r5_wide_opcode: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_wide) |-> (out_opcode == WIDE_OPC));
endmodule

bind wide_insn_decoder wid_decoder_checker #(
    .REG_MAX  (REG_MAX),
    .WIDE_OPC (WIDE_OPC)
) i_wid_checker (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_opcode (out_opcode),
    .out_src    (out_src),
    .out_dst    (out_dst),
    .out_imm    (out_imm),
    .out_wide   (out_wide),
    .out_err    (out_err)
);

// File: tb/test_wide_insn_decoder.sv
`timescale 1ns/1ps
module test_wide_insn_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_word;
    logic        out_ready;
    logic        out_valid;
    logic [7:0]  out_opcode;
    logic [2:0]  out_class;
    logic [3:0]  out_alu_op;
    logic        out_src_sel;
    logic [3:0]  out_src;
    logic [3:0]  out_dst;
    logic [63:0] out_offset;
    logic [63:0] out_imm;
    logic        out_wide;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wide_insn_decoder i_wide_insn_decoder (
        .clk, .rst, .in_valid, .in_ready, .in_word, .out_ready, .out_valid,
        .out_opcode, .out_class, .out_alu_op, .out_src_sel, .out_src,
        .out_dst, .out_offset, .out_imm, .out_wide, .out_err
    );

    function automatic logic [63:0] mk(input logic [31:0] imm, input logic [15:0] off,
                                       input logic [3:0] src, input logic [3:0] dst,
                                       input logic [7:0] opc);
        return {imm, off, src, dst, opc};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word, return at the negedge after the accepting edge
    task automatic push(input logic [63:0] w);
        in_word  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_record();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9 out_valid after release", 64'(out_valid), 64'd0);
        chk("R9 in_ready after release", 64'(in_ready), 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 out_err", 64'(out_err), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
    endtask

    task automatic t_basic_negative();
        logic [63:0] held;
        push(mk(32'hFFFF_FFF0, 16'h8001, 4'd3, 4'd10, 8'h0F));
        chk("R10 out_valid next cycle", 64'(out_valid), 64'd1);
        chk("R3 imm sign ext", out_imm, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R3 offset sign ext", out_offset, 64'hFFFF_FFFF_FFFF_8001);
        chk("R2 src", 64'(out_src), 64'd3);
        chk("R2 dst", 64'(out_dst), 64'd10);
        chk("R2 opcode", 64'(out_opcode), 64'h0F);
        chk("R2 alu_op", 64'(out_alu_op), 64'h0);
        chk("R2 src_sel", 64'(out_src_sel), 64'd1);
        chk("R2 class", 64'(out_class), 64'd7);
        chk("R2 wide", 64'(out_wide), 64'd0);
        held = out_imm;
        // R8: competing word while held
        in_word  = mk(32'h5555_5555, 16'h0, 4'd1, 4'd1, 8'h07);
        in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 in_ready low", 64'(in_ready), 64'd0);
            chk("R8 record held", out_imm, held);
        end
        in_valid = 1'b0;
        pop_record();
    endtask

    task automatic t_basic_positive();
        push(mk(32'h1234_5678, 16'h0010, 4'd0, 4'd0, 8'h57));
        chk("R3 imm positive", out_imm, 64'h0000_0000_1234_5678);
        chk("R3 offset positive", out_offset, 64'h10);
        chk("R2 alu_op", 64'(out_alu_op), 64'h5);
        chk("R2 src_sel imm", 64'(out_src_sel), 64'd0);
        chk("R2 class", 64'(out_class), 64'd7);
        pop_record();
    endtask

    task automatic t_reg_errors();
        push(mk(32'h1, 16'h0, 4'd11, 4'd0, 8'h0C));
        chk("R4 err on src 11", 64'(out_err), 64'd1);
        chk("R4 no record", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R4 err one cycle", 64'(out_err), 64'd0);
        push(mk(32'h1, 16'h0, 4'd0, 4'd15, 8'h04));
        chk("R4 err on dst 15", 64'(out_err), 64'd1);
        chk("R4 no record dst", 64'(out_valid), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_wide_ok();
        push(mk(32'h89AB_CDEF, 16'h0, 4'd13, 4'd2, 8'h18));
        chk("R5 waits after first slot", 64'(out_valid), 64'd0);
        chk("R5 src not range checked", 64'(out_err), 64'd0);
        push(mk(32'h0123_4567, 16'h0, 4'd0, 4'd0, 8'h00));
        chk("R5 valid", 64'(out_valid), 64'd1);
        chk("R5 imm64", out_imm, 64'h0123_4567_89AB_CDEF);
        chk("R5 wide flag", 64'(out_wide), 64'd1);
        chk("R5 dst", 64'(out_dst), 64'd2);
        chk("R5 src", 64'(out_src), 64'd13);
        chk("R5 opcode", 64'(out_opcode), 64'h18);
        pop_record();
    endtask

    task automatic t_wide_bad_pseudo();
        push(mk(32'h1111_2222, 16'h0, 4'd0, 4'd1, 8'h18));
        push(mk(32'h0, 16'h0004, 4'd0, 4'd0, 8'h00));
        chk("R6 err on dirty pseudo", 64'(out_err), 64'd1);
        chk("R6 pair dropped", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R6 err one cycle", 64'(out_err), 64'd0);
        push(mk(32'h0000_0042, 16'h0, 4'd0, 4'd5, 8'h07));
        chk("R6 resync valid", 64'(out_valid), 64'd1);
        chk("R6 resync basic", 64'(out_wide), 64'd0);
        chk("R6 resync imm", out_imm, 64'h42);
        pop_record();
    endtask

    task automatic t_wide_bad_dst();
        push(mk(32'h7, 16'h0, 4'd0, 4'd12, 8'h18));
        chk("R7 err on wide dst", 64'(out_err), 64'd1);
        @(negedge clk);
        push(mk(32'h0000_0009, 16'h0, 4'd0, 4'd4, 8'h07));
        chk("R7 next word is first slot", 64'(out_valid), 64'd1);
        chk("R7 not wide", 64'(out_wide), 64'd0);
        chk("R7 dst", 64'(out_dst), 64'd4);
        pop_record();
    endtask

    initial begin
        t_reset();
        t_basic_negative();
        t_basic_positive();
        t_reg_errors();
        t_wide_ok();
        t_wide_bad_pseudo();
        t_wide_bad_dst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule